// File: doc/BRIEF.md
# Expression Evaluation Stack with Fused ALU

This block is the operand stack of a stack-oriented processor core. It keeps up to seven 32-bit words in registers and has an integer and logic unit attached directly to its top two slots. Each cycle it accepts one command: push a value carried on the data input, such as an immediate constant, drop the top word, or execute an operation. A binary operation reads the top two words in the same cycle through two read ports. It removes both and leaves the result on top, all in one clock. A unary operation overwrites the top word in place.

The top two words, the current depth and two sticky error flags are visible at the ports. Spilling to memory is the job of the compiler or an outside controller. Such a controller can watch the depth and issue pops and pushes to spill or reload words. A push onto a full stack or any command that lacks operands is refused. The contents stay as they were and the matching flag is raised.

Top module: `expr_stack`

## Requirements
- R1: After reset the depth is 0, both flags are 0, and top_o and next_o read 0.
- R2: cmd_i=1 (push) on a stack that is not full stores data_i as the new top and raises the depth by one. The former top then shows on next_o, visible after the next rising clock edge.
- R3: cmd_i=2 (pop) on a non-empty stack removes the top word and lowers the depth by one.
- R4: cmd_i=3 (execute) with op_i below 8 is binary: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right. The result is next op top (next minus top for subtract) and is computed modulo 2^32. The result replaces both operands within one cycle, so the depth drops by one.
- R5: Binary op_i=7 compares next and top for equality and leaves 1 if they are equal and 0 otherwise. Shifts move next by the amount in top bits [4:0].
- R6: cmd_i=3 with op_i bit 3 set is unary and uses op_i bit 0 to choose the operation: 0 gives bitwise NOT and 1 gives two's complement negate. The result replaces the top word and the depth is unchanged. op_i bits [2:1] are ignored.
- R7: A push while the depth is 7 sets the sticky overflow flag ovf_o and changes neither the depth nor the contents.
- R8: A pop at depth 0 sets the sticky underflow flag udf_o and leaves the stack unchanged. So does an execute whose operands are not all present (binary below depth 2, unary at depth 0).
- R9: The flags stay set until reset, and the stack keeps operating normally while they are set.
- R10: cmd_i=0 changes nothing. A missing top or next word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 0 none, 1 push, 2 pop, 3 execute |
| op_i | input | 4 | Operation code for execute |
| data_i | input | 32 | Value to push |
| top_o | output | 32 | Top word, 0 when empty |
| next_o | output | 32 | Second word, 0 when depth below 2 |
| depth_o | output | 3 | Number of words held |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
The hardest states to reach are at the edges of the stack: a full stack that is then pushed again, and a binary operation issued with only one operand. The stimulus fills the stack with seven distinct pushes and then pushes once more. The top and next words must still hold the last two values pushed. Reset clears the flags so that each refusal can be seen on its own. The bench then holds one word and executes a binary operation, and separately executes a unary operation on an empty stack. In both cases it checks that nothing moved and that only the underflow flag rose.

// File: rtl/expr_stack_pkg.sv
package expr_stack_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_PUSH = 2'd1,
    CMD_POP  = 2'd2,
    CMD_EXEC = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_EQ  = 4'd7
  } op_e;
endpackage

// File: rtl/expr_stack_alu.sv
module expr_stack_alu #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,   // second word
  input  logic [WIDTH-1:0] b_i,   // top word
  output logic [WIDTH-1:0] res_o
);
  import expr_stack_pkg::*;
  localparam int SHW = $clog2(WIDTH);

  logic [SHW-1:0] sh;
  assign sh = b_i[SHW-1:0];

  always_comb begin
    res_o = '0;
    if (op_i[3]) begin
      res_o = op_i[0] ? (~b_i + 1'b1) : ~b_i;
    end else begin
      case (op_e'(op_i))
        OP_ADD: res_o = a_i + b_i;
        OP_SUB: res_o = a_i - b_i;
        OP_AND: res_o = a_i & b_i;
        OP_OR:  res_o = a_i | b_i;
        OP_XOR: res_o = a_i ^ b_i;
        OP_SHL: res_o = a_i << sh;
        OP_SHR: res_o = a_i >> sh;
        default: res_o = {{(WIDTH-1){1'b0}}, (a_i == b_i)};
      endcase
    end
  end
endmodule

// File: rtl/expr_stack_regs.sv
module expr_stack_regs #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 7,
  parameter int AW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr0_i,
  input  logic [AW-1:0]    raddr1_i,
  output logic [WIDTH-1:0] rdata0_o,
  output logic [WIDTH-1:0] rdata1_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           slot_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))    slot_q[g] <= wdata_i;
    end
  end

  // two independent read ports, out-of-range address reads zero
  always_comb begin
    rdata0_o = '0;
    rdata1_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr0_i == AW'(i)) rdata0_o = slot_q[i];
      if (raddr1_i == AW'(i)) rdata1_o = slot_q[i];
    end
  end
endmodule

// File: rtl/expr_stack_ctrl.sv
module expr_stack_ctrl #(
  parameter int DEPTH = 7,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cmd_i,
  input  logic [3:0]    op_i,
  output logic [AW-1:0] depth_o,
  output logic          ovf_o,
  output logic          udf_o,
  output logic          we_o,
  output logic          sel_alu_o,
  output logic [AW-1:0] waddr_o
);
  import expr_stack_pkg::*;
  localparam logic [AW-1:0] FULL = AW'(DEPTH);

  logic [AW-1:0] depth_q, depth_d;
  logic          ovf_q, udf_q, ovf_set, udf_set;
  logic          unary;

  assign unary = op_i[3];

  always_comb begin
    depth_d   = depth_q;
    ovf_set   = 1'b0;
    udf_set   = 1'b0;
    we_o      = 1'b0;
    sel_alu_o = 1'b0;
    waddr_o   = depth_q;
    case (cmd_e'(cmd_i))
      CMD_PUSH: begin
        if (depth_q == FULL) ovf_set = 1'b1;
        else begin
          we_o    = 1'b1;
          depth_d = depth_q + 1'b1;
        end
      end
      CMD_POP: begin
        if (depth_q == '0) udf_set = 1'b1;
        else               depth_d = depth_q - 1'b1;
      end
      CMD_EXEC: begin
        if (unary) begin
          if (depth_q == '0) udf_set = 1'b1;
          else begin
            we_o      = 1'b1;
            sel_alu_o = 1'b1;
            waddr_o   = depth_q - 1'b1;
          end
        end else begin
          if (depth_q < AW'(2)) udf_set = 1'b1;
          else begin
            we_o      = 1'b1;
            sel_alu_o = 1'b1;
            waddr_o   = depth_q - AW'(2);
            depth_d   = depth_q - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      depth_q <= depth_d;
      ovf_q   <= ovf_q | ovf_set;
      udf_q   <= udf_q | udf_set;
    end
  end

  assign depth_o = depth_q;
  assign ovf_o   = ovf_q;
  assign udf_o   = udf_q;
endmodule

// File: rtl/expr_stack.sv
module expr_stack #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 7,
  localparam int AW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cmd_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] top_o,
  output logic [WIDTH-1:0] next_o,
  output logic [AW-1:0]    depth_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic             we, sel_alu;
  logic [AW-1:0]    waddr, depth;
  logic [WIDTH-1:0] rd0, rd1, alu_res, wdata;

  expr_stack_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .cmd_i, .op_i,
    .depth_o(depth), .ovf_o, .udf_o,
    .we_o(we), .sel_alu_o(sel_alu), .waddr_o(waddr)
  );

  expr_stack_regs #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr0_i(depth - 1'b1), .raddr1_i(depth - AW'(2)),
    .rdata0_o(rd0), .rdata1_o(rd1)
  );

  expr_stack_alu #(.WIDTH(WIDTH)) u_alu (
    .op_i, .a_i(rd1), .b_i(rd0), .res_o(alu_res)
  );

  assign wdata   = sel_alu ? alu_res : data_i;
  assign top_o   = (depth != '0)     ? rd0 : '0;
  assign next_o  = (depth >= AW'(2)) ? rd1 : '0;
  assign depth_o = depth;
endmodule

// File: rtl/expr_stack_chk.sv
module expr_stack_chk #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 7,
  localparam int AW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       cmd_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] top_o,
  input logic [WIDTH-1:0] next_o,
  input logic [AW-1:0]    depth_o,
  input logic             ovf_o,
  input logic             udf_o
);
  localparam logic [AW-1:0] FULL = AW'(DEPTH);

  // R2
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 && depth_o != FULL) |=> (top_o == $past(data_i) && depth_o == $past(depth_o) + 1'b1));
  // R3
  pop_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd2 && depth_o != '0) |=> (depth_o == $past(depth_o) - 1'b1));
  // R4
  bin_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd3 && !op_i[3] && depth_o >= AW'(2)) |=> (depth_o == $past(depth_o) - 1'b1));
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 && depth_o == FULL) |=> (ovf_o && $stable(depth_o) && $stable(top_o) && $stable(next_o)));
  // R8
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd2 && depth_o == '0) |=> (udf_o && depth_o == '0));
  // R9
  sticky_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) ovf_o |=> ovf_o);
  // R9
  sticky_udf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) udf_o |=> udf_o);
  // R10
  depth_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o <= FULL) && (depth_o != '0 || top_o == '0));
endmodule

bind expr_stack expr_stack_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/expr_stack_bench.sv
module expr_stack_bench;
  localparam int VW = 105;
  localparam int NV = 27;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]  cmd_i = '0;
  logic [3:0]  op_i = '0;
  logic [31:0] data_i = '0;
  logic [31:0] top_o, next_o;
  logic [2:0]  depth_o;
  logic        ovf_o, udf_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  expr_stack u_expr_stack (.*);

  // {cmd, op, data, exp_top, exp_next, exp_depth}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd1, 4'd0, 32'h5,          32'h5,          32'h0,          3'd1},
    {2'd1, 4'd0, 32'h3,          32'h3,          32'h5,          3'd2},
    {2'd3, 4'd1, 32'h0,          32'h2,          32'h0,          3'd1},
    {2'd1, 4'd0, 32'h7,          32'h7,          32'h2,          3'd2},
    {2'd3, 4'd0, 32'h0,          32'h9,          32'h0,          3'd1},
    {2'd1, 4'd0, 32'hA,          32'hA,          32'h9,          3'd2},
    {2'd3, 4'd1, 32'h0,          32'hFFFF_FFFF,  32'h0,          3'd1},
    {2'd1, 4'd0, 32'h1,          32'h1,          32'hFFFF_FFFF,  3'd2},
    {2'd3, 4'd0, 32'h0,          32'h0,          32'h0,          3'd1},
    {2'd3, 4'd8, 32'h0,          32'hFFFF_FFFF,  32'h0,          3'd1},
    {2'd1, 4'd0, 32'hF0F0_F0F0,  32'hF0F0_F0F0,  32'hFFFF_FFFF,  3'd2},
    {2'd3, 4'd2, 32'h0,          32'hF0F0_F0F0,  32'h0,          3'd1},
    {2'd1, 4'd0, 32'h0FF0_0FF0,  32'h0FF0_0FF0,  32'hF0F0_F0F0,  3'd2},
    {2'd3, 4'd3, 32'h0,          32'hFFF0_FFF0,  32'h0,          3'd1},
    {2'd1, 4'd0, 32'hFFFF_0000,  32'hFFFF_0000,  32'hFFF0_FFF0,  3'd2},
    {2'd3, 4'd4, 32'h0,          32'h000F_FFF0,  32'h0,          3'd1},
    {2'd1, 4'd0, 32'h4,          32'h4,          32'h000F_FFF0,  3'd2},
    {2'd3, 4'd5, 32'h0,          32'h00FF_FF00,  32'h0,          3'd1},
    {2'd1, 4'd0, 32'h24,         32'h24,         32'h00FF_FF00,  3'd2},
    {2'd3, 4'd6, 32'h0,          32'h000F_FFF0,  32'h0,          3'd1},
    {2'd3, 4'd15,32'h0,          32'hFFF0_0010,  32'h0,          3'd1},
    {2'd1, 4'd0, 32'hFFF0_0010,  32'hFFF0_0010,  32'hFFF0_0010,  3'd2},
    {2'd3, 4'd7, 32'h0,          32'h1,          32'h0,          3'd1},
    {2'd1, 4'd0, 32'h2,          32'h2,          32'h1,          3'd2},
    {2'd3, 4'd7, 32'h0,          32'h0,          32'h0,          3'd1},
    {2'd2, 4'd0, 32'h0,          32'h0,          32'h0,          3'd0},
    {2'd0, 4'd0, 32'h0,          32'h0,          32'h0,          3'd0}
  };

  task automatic check(string req, logic [31:0] t, logic [31:0] n, logic [2:0] d,
                       logic ov, logic ud);
    total++;
    if (top_o !== t || next_o !== n || depth_o !== d || ovf_o !== ov || udf_o !== ud) begin
      bad++;
      $display("FAIL %s: got top=%h next=%h depth=%0d ovf=%b udf=%b exp top=%h next=%h depth=%0d ovf=%b udf=%b",
               req, top_o, next_o, depth_o, ovf_o, udf_o, t, n, d, ov, ud);
    end
  endtask

  task automatic step(logic [1:0] c, logic [3:0] o, logic [31:0] v);
    @(negedge clk_i);
    cmd_i = c; op_i = o; data_i = v;
    @(posedge clk_i);
    #1;
    cmd_i = 2'd0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cmd_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
  endtask

  initial begin
    do_reset();
    check("R1 reset", 0, 0, 0, 0, 0);

    // R2 R3 R4 R5 R6 R10 vector walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][104:103], VEC[i][102:99], VEC[i][98:67]);
      check($sformatf("R2/R3/R4/R5/R6/R10 vec%0d", i),
            VEC[i][66:35], VEC[i][34:3], VEC[i][2:0], 0, 0);
    end

    // R7 fill then push on full
    for (int k = 1; k <= 7; k++) step(2'd1, 4'd0, 32'(k * 11));
    check("R2 full", 77, 66, 7, 0, 0);
    step(2'd1, 4'd0, 32'hDEAD);
    check("R7 push on full", 77, 66, 7, 1, 0);
    // R9 stack still works, flag sticky
    step(2'd2, 4'd0, 0);
    check("R9 pop after ovf", 66, 55, 6, 1, 0);
    for (int k = 0; k < 6; k++) step(2'd2, 4'd0, 0);
    check("R3 drained", 0, 0, 0, 1, 0);
    step(2'd2, 4'd0, 0);
    check("R8 pop empty", 0, 0, 0, 1, 1);

    // R8 binary op with one operand
    do_reset();
    check("R1 reset again", 0, 0, 0, 0, 0);
    step(2'd1, 4'd0, 32'h5);
    step(2'd3, 4'd0, 0);
    check("R8 binary short", 5, 0, 1, 0, 1);
    step(2'd1, 4'd0, 32'h3);
    check("R9 push after udf", 3, 5, 2, 0, 1);
    step(2'd3, 4'd0, 0);
    check("R9 add after udf", 8, 0, 1, 0, 1);

    // R8 unary on empty
    do_reset();
    step(2'd3, 4'd8, 0);
    check("R8 unary empty", 0, 0, 0, 0, 1);

    // R6 op bits [2:1] ignored for unary: 0xE = NOT
    do_reset();
    step(2'd1, 4'd0, 32'h0000_00FF);
    step(2'd3, 4'hE, 0);
    check("R6 unary bits ignored", 32'hFFFF_FF00, 0, 1, 0, 0);
    // R10 nop
    step(2'd0, 4'd0, 32'h1234);
    check("R10 nop", 32'hFFFF_FF00, 0, 1, 0, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule